// File: doc/BRIEF.md
# Inverse Haar Lifting Merge Unit

This unit rebuilds the original sample stream from the coefficients that a forward integer Haar lifting engine produced. Each input transfer carries one coarse (average) coefficient and the detail (difference) coefficient that belongs to it. The unit first undoes the update step, which gives back the even sample. It then undoes the predict step with that even sample, which gives back the odd sample. Because both steps use the same integer arithmetic as the forward engine in reverse order and with opposite signs, the reconstruction is lossless.

A merge sequencer puts the two recovered samples back into their original order on one registered output stream. The even sample comes out in the first slot and the odd sample in the second. A new pair is therefore taken at most once every two enabled cycles. A clock-enable input freezes the whole unit without losing state.

Top module: `haar_inverse_merge`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves out_valid at 0 and in_ready at 1 after that edge.
- R2: A pair is accepted at a rising edge where en, in_valid and in_ready are all 1. After that edge out_valid is 1 and out_sample holds the even sample, equal to coarse − (detail >>> 1), where >>> is an arithmetic (floor) shift right by one.
- R3: At the next enabled edge the unit emits the odd sample, equal to detail + even, with out_valid at 1.
- R4: For each pair the even sample always comes out before the odd sample, in consecutive enabled output slots.
- R5: in_ready is 0 while the odd sample is pending. A pair offered during that cycle is not taken, and the output is unchanged by it. The same pair is taken once in_ready returns to 1.
- R6: While en is 0 no pair is accepted and the sequence does not advance. After such an edge out_valid is 0, and out_sample and in_ready keep their values.
- R7: For any even and odd samples in the signed WIDTH-bit range, including both extremes, a pair made by the forward steps (detail = odd − even, coarse = even + (detail >>> 1)) is rebuilt bit-exactly. coarse is WIDTH bits and detail is WIDTH+1 bits, both two's complement.
- R8: With in_valid held at 1, one pair is accepted every two cycles, and out_valid stays at 1 on every cycle of the stream.
- R9: An enabled edge with in_ready at 1 and in_valid at 0 leaves out_valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; the unit computes only when high |
| in_valid | input | 1 | Coefficient pair present |
| in_ready | output | 1 | Unit can take a pair (even slot) |
| coarse | input | WIDTH | Coarse coefficient, signed |
| detail | input | WIDTH+1 | Detail coefficient, signed |
| out_valid | output | 1 | out_sample carries a reconstructed sample |
| out_sample | output | WIDTH | Reconstructed sample, signed, even then odd |

## Verification
The bench aims at negative odd details, where a logical shift or a rounding shift in place of the floor shift would make the even sample wrong by one or by a large amount. It also uses the most negative and most positive samples, where a truncated intermediate width would wrap. A pair offered while the odd sample is pending must not replace the pending odd value or be lost. A design that ignored in_ready would either skip the odd sample or emit data from the wrong pair. Enable-low stretches must freeze both slots; a design that let the phase advance or kept out_valid high would drop or repeat samples.

// File: rtl/ihl_pkg.sv
package ihl_pkg;
  // Output slot of the merge sequencer
  typedef enum logic {
    SLOT_EVEN = 1'b0,
    SLOT_ODD  = 1'b1
  } slot_e;
endpackage

// File: rtl/ihl_undo_update.sv
module ihl_undo_update #(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chk_en,
  input  logic signed [WIDTH-1:0] coarse,
  input  logic signed [WIDTH:0]   detail,
  output logic signed [WIDTH-1:0] even
);
  localparam int EXT = WIDTH + 1;

  logic signed [EXT-1:0] half_d;
  logic signed [EXT-1:0] diff;

  always_comb begin
    half_d = detail >>> 1;
    diff   = {coarse[WIDTH-1], coarse} - half_d;
    even   = diff[WIDTH-1:0];
  end

  // R7
  even_range_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> (diff[EXT-1] == diff[WIDTH-1]));
endmodule

// File: rtl/ihl_undo_predict.sv
module ihl_undo_predict #(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chk_en,
  input  logic signed [WIDTH-1:0] even,
  input  logic signed [WIDTH:0]   detail,
  output logic signed [WIDTH-1:0] odd
);
  localparam int EXT = WIDTH + 1;

  logic signed [EXT-1:0] sum;

  always_comb begin
    sum = detail + {even[WIDTH-1], even};
    odd = sum[WIDTH-1:0];
  end

  // R7
  odd_range_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> (sum[EXT-1] == sum[WIDTH-1]));
endmodule

// File: rtl/ihl_merge_seq.sv
module ihl_merge_seq
  import ihl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_valid,
  input  logic signed [WIDTH-1:0] even,
  input  logic signed [WIDTH-1:0] odd,
  output logic                    in_ready,
  output logic                    accept,
  output logic                    out_valid,
  output logic signed [WIDTH-1:0] out_sample
);
  slot_e                   slot_q;
  logic signed [WIDTH-1:0] odd_q;

  assign in_ready = (slot_q == SLOT_EVEN);
  assign accept   = en && in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= SLOT_EVEN;
      odd_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (en) begin
      unique case (slot_q)
        SLOT_EVEN: begin
          if (in_valid) begin
            out_sample <= even;
            odd_q      <= odd;
            slot_q     <= SLOT_ODD;
            out_valid  <= 1'b1;
          end else begin
            out_valid  <= 1'b0;
          end
        end
        SLOT_ODD: begin
          out_sample <= odd_q;
          slot_q     <= SLOT_EVEN;
          out_valid  <= 1'b1;
        end
        default: out_valid <= 1'b0;
      endcase
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R2
  even_slot_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && !in_ready && out_sample == $past(even)));

  // R3
  odd_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !in_ready) |=> (out_valid && in_ready));

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!out_valid && $stable(out_sample) && $stable(in_ready)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && in_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/haar_inverse_merge.sv
module haar_inverse_merge #(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [WIDTH-1:0] coarse,
  input  logic signed [WIDTH:0]   detail,
  output logic                    out_valid,
  output logic signed [WIDTH-1:0] out_sample
);
  logic signed [WIDTH-1:0] even_w;
  logic signed [WIDTH-1:0] odd_w;
  logic                    accept_w;

  ihl_undo_update #(.WIDTH(WIDTH)) u_update (
    .clk    (clk),
    .rst    (rst),
    .chk_en (accept_w),
    .coarse (coarse),
    .detail (detail),
    .even   (even_w)
  );

  ihl_undo_predict #(.WIDTH(WIDTH)) u_predict (
    .clk    (clk),
    .rst    (rst),
    .chk_en (accept_w),
    .even   (even_w),
    .detail (detail),
    .odd    (odd_w)
  );

  ihl_merge_seq #(.WIDTH(WIDTH)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .in_valid   (in_valid),
    .even       (even_w),
    .odd        (odd_w),
    .in_ready   (in_ready),
    .accept     (accept_w),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  // Shadow of the accepted pair for the lossless check
  logic signed [WIDTH:0]   det_q;
  logic signed [WIDTH-1:0] ev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= '0;
      ev_q  <= '0;
    end else if (accept_w) begin
      det_q <= detail;
      ev_q  <= even_w;
    end
  end

  // R7
  lossless_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !in_ready) |=>
      (({out_sample[WIDTH-1], out_sample} - {ev_q[WIDTH-1], ev_q}) == det_q));
endmodule

// File: tb/test_haar_inverse_merge.sv
module test_haar_inverse_merge;
  localparam int WIDTH = 8;
  localparam int SMIN  = -(1 << (WIDTH - 1));
  localparam int SMAX  = (1 << (WIDTH - 1)) - 1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    en = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic signed [WIDTH-1:0] coarse = '0;
  logic signed [WIDTH:0]   detail = '0;
  logic                    out_valid;
  logic signed [WIDTH-1:0] out_sample;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  haar_inverse_merge #(.WIDTH(WIDTH)) i_haar_inverse_merge (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .coarse     (coarse),
    .detail     (detail),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expect_eq(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Forward lifting model built from the requirement text
  task automatic fwd(input int e, input int o, output int s, output int d);
    d = o - e;
    s = e + (d >>> 1);
  endtask

  task automatic present(input int e, input int o);
    int s;
    int d;
    fwd(e, o, s, d);
    coarse   = s[WIDTH-1:0];
    detail   = d[WIDTH:0];
    in_valid = 1'b1;
  endtask

  task automatic check_out(input string req, input int exp, input int rdy);
    expect_eq({req, " valid"}, int'(out_valid), 1);
    expect_eq({req, " sample"}, int'(out_sample), exp);
    expect_eq({req, " ready"}, int'(in_ready), rdy);
  endtask

  // Single pair: even slot then odd slot
  task automatic t_pair(input int e, input int o, input string req);
    @(negedge clk);
    en = 1'b1;
    present(e, o);
    @(negedge clk);
    in_valid = 1'b0;
    check_out({req, " R2 R4 even"}, e, 0);
    @(negedge clk);
    check_out({req, " R3 R4 odd"}, o, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_eq("R1 out_valid", int'(out_valid), 0);
    expect_eq("R1 in_ready", int'(in_ready), 1);
    rst = 1'b0;
  endtask

  task automatic t_idle;
    @(negedge clk);
    en = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    expect_eq("R9 idle out_valid", int'(out_valid), 0);
    expect_eq("R9 idle in_ready", int'(in_ready), 1);
  endtask

  task automatic t_not_ready;
    @(negedge clk);
    en = 1'b1;
    present(10, -7);
    @(negedge clk);
    check_out("R5 first even", 10, 0);
    present(-50, 33);
    @(negedge clk);
    check_out("R5 odd kept", -7, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R5 late even", -50, 0);
    @(negedge clk);
    check_out("R5 late odd", 33, 1);
  endtask

  task automatic t_stall;
    int held;
    @(negedge clk);
    held = int'(out_sample);
    en = 1'b0;
    present(5, 6);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_eq("R6 idle stall valid", int'(out_valid), 0);
      expect_eq("R6 idle stall sample", int'(out_sample), held);
      expect_eq("R6 idle stall ready", int'(in_ready), 1);
    end
    en = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R6 even after stall", 5, 0);
    en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      expect_eq("R6 mid stall valid", int'(out_valid), 0);
      expect_eq("R6 mid stall sample", int'(out_sample), 5);
      expect_eq("R6 mid stall ready", int'(in_ready), 0);
    end
    en = 1'b1;
    @(negedge clk);
    check_out("R6 odd after stall", 6, 1);
  endtask

  task automatic t_stream;
    int ev[6] = '{3, -128, 127, -1, 64, -90};
    int od[6] = '{-4, 127, -128, -2, 65, -91};
    @(negedge clk);
    en = 1'b1;
    present(ev[0], od[0]);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check_out("R8 stream even", ev[k], 0);
      if (k < 5) present(ev[k+1], od[k+1]);
      else in_valid = 1'b0;
      @(negedge clk);
      check_out("R8 stream odd", od[k], 1);
    end
  endtask

  task automatic t_sweep;
    for (int e = SMIN; e <= SMAX; e += 17) begin
      for (int o = SMAX; o >= SMIN; o -= 23) begin
        t_pair(e, o, "R7 sweep");
      end
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_pair(20, 25, "R2 positive");
    t_pair(7, 0, "R2 negative odd detail");
    t_pair(-3, -8, "R3 negative");
    t_pair(SMIN, SMAX, "R7 min max");
    t_pair(SMAX, SMIN, "R7 max min");
    t_pair(SMIN, SMIN, "R7 min min");
    t_pair(SMAX, SMAX, "R7 max max");
    t_not_ready();
    t_stall();
    t_stream();
    t_sweep();
    t_idle();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule